// File: doc/BRIEF.md
# Two-Bank Edge-Latching Interrupt Controller

This block gathers 64 interrupt inputs into two banks of 32 and drives a single request line towards a processor. Each input passes through a two-flop synchronizer. A rising edge on an enabled input sets a sticky event bit. The processor clears that bit by writing a one to the matching acknowledge position. A source is pending while its enable bit is set and either its event bit or its live synchronized level is high. The request output is the registered OR of every pending source.

Software reaches the block over a 32-bit word register bus within a 64-byte window. Writes are taken on the clock edge and reads are combinational. The window holds a read-only vector word that names the highest-numbered pending source. Each bank has four words: event, enable, acknowledge and live level.

The bank for sources 32–63 sits below the bank for sources 0–31 in the window. A second controller of the same kind can be cascaded by wiring its request output to one input of this controller.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Word map by `addr_i[5:2]`. The vector is at 0x00. The bank for sources 32–63 is at base 0x10, and the bank for sources 0–31 is at base 0x20. Within a bank, event is at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Bit j of a bank word is source base_source+j. Acknowledge words and all unmapped words read as zero.
- R2: While `rst_n` is low, all enable bits, all event bits and `irq_o` are zero, and the synchronizers are cleared.
- R3: A rising edge on an input is latched into its event bit only if the enable bit is 1 in the cycle the edge is seen. An input that goes high before clock edge k is visible in the level word after edge k+1. Its event bit is set at edge k+2. An edge on a disabled source leaves its event bit at 0.
- R4: Setting an enable bit while the matching input is already steadily high does not set that event bit.
- R5: Writing 1 to an acknowledge bit clears that event bit at the write edge. Writing 0 leaves the bit unchanged. If a rising edge is latched in the same cycle as the acknowledge, the event bit stays set.
- R6: An enable word reads back exactly the value last written to it, from the edge after the write.
- R7: A level word returns the synchronized, unlatched state of its 32 inputs.
- R8: Source i is pending when (event_i OR level_i) AND enable_i. The vector word carries the index of the highest-numbered pending source in bits [5:0] and a 1 in bit 31. It reads as zero when nothing is pending.
- R9: `irq_o` equals the OR of all pending bits as they stood in the previous cycle.
- R10: Clearing an enable bit drops the source from pending and from the vector, but keeps its latched event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Asynchronous interrupt inputs, bit i is source i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address in the window, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The race that matters is an acknowledge write landing in the same cycle that a fresh rising edge is being latched for the same source. The bench toggles source 0 and issues the acknowledge at several cycle offsets from the rise, so that one offset lands exactly on the latch cycle. In every case the cycle-accurate model must predict the surviving event bit. A second overlap occurs when an enable write coincides with an edge already in the synchronizer. Here the model uses the old enable for that cycle, and the bench judges the event word read back after the write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned NUM_SRC   = DATA_W * NUM_BANKS;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned ADDR_W    = 6;

  typedef enum logic [1:0] {
    REG_EVT = 2'd0,
    REG_EN  = 2'd1,
    REG_ACK = 2'd2,
    REG_LVL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W     = 32,
  parameter int unsigned SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] level_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] sync_q [SYNC];
  logic [W-1:0] prev_q;
  logic [W-1:0] evt_q, evt_d;
  logic [W-1:0] en_q;
  logic [W-1:0] rise;
  logic [W-1:0] ack_mask;

  assign level_o = sync_q[SYNC-1];

  always_comb begin
    rise     = level_o & ~prev_q;
    ack_mask = ack_we_i ? wdata_i : '0;
    evt_d    = (evt_q & ~ack_mask) | (rise & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= level_o;
      evt_q  <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we_i) begin
      en_q <= wdata_i;
    end
  end

  assign event_o  = evt_q;
  assign enable_o = en_q;
  assign pend_o   = (evt_q | level_o) & en_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 4;

  logic [NUM_SRC-1:0]   evt_all, en_all, lvl_all, pend_all;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [1:0]           reg_off;
  logic [BLK_W-1:0]     blk;
  logic                 vec_valid;
  logic [IDX_W-1:0]     vec_idx;
  logic                 irq_d, irq_q;

  assign reg_off = addr_i[3:2];
  assign blk     = addr_i[ADDR_W-1:4];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * DATA_W;
    logic en_we, ack_we;
    assign bank_hit[b] = (blk == BLK_W'(NUM_BANKS - b));
    assign en_we  = wr_en_i & bank_hit[b] & (reg_off == REG_EN);
    assign ack_we = wr_en_i & bank_hit[b] & (reg_off == REG_ACK);

    irq_bank #(.W(DATA_W), .SYNC(2)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[LO +: DATA_W]),
      .en_we_i  (en_we),
      .ack_we_i (ack_we),
      .wdata_i  (wdata_i),
      .event_o  (evt_all[LO +: DATA_W]),
      .enable_o (en_all[LO +: DATA_W]),
      .level_o  (lvl_all[LO +: DATA_W]),
      .pend_o   (pend_all[LO +: DATA_W])
    );
  end

  irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i  (pend_all),
    .valid_o (vec_valid),
    .idx_o   (vec_idx)
  );

  always_comb begin
    rdata_o = '0;
    if (blk == '0 && reg_off == 2'd0) begin
      rdata_o[DATA_W-1]  = vec_valid;
      rdata_o[IDX_W-1:0] = vec_idx;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (reg_off)
          REG_EVT: rdata_o = evt_all[b*DATA_W +: DATA_W];
          REG_EN:  rdata_o = en_all[b*DATA_W +: DATA_W];
          REG_LVL: rdata_o = lvl_all[b*DATA_W +: DATA_W];
          default: rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_d = |pend_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
  import irq_bank_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] en
);
  logic en_wr;
  assign en_wr = wr_en_i && (addr_i == 6'h24 || addr_i == 6'h14);

  p_en_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 6'h24) |=> en[31:0] == $past(wdata_i));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en));

  p_evt_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(evt) & ~$past(en)) == '0));

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == (|$past(pend)));

  p_irq_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq_o);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .pend    (pend_all),
  .evt     (evt_all),
  .en      (en_all)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic        wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference: hist holds [prev, sync2, sync1]
  bit [63:0] m_ev, m_en;
  bit [63:0] hist[$];
  bit        m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ev = '0; m_en = '0; m_irq = 0;
      hist = '{64'd0, 64'd0, 64'd0};
    end else begin
      bit [63:0] rise, ack, old_en;
      rise   = hist[1] & ~hist[0];
      old_en = m_en;
      m_irq  = |((m_ev | hist[1]) & m_en);
      ack    = '0;
      if (wr_en && addr == 6'h28) ack[31:0]  = wdata;
      if (wr_en && addr == 6'h18) ack[63:32] = wdata;
      m_ev = (m_ev & ~ack) | (rise & old_en);
      if (wr_en && addr == 6'h24) m_en[31:0]  = wdata;
      if (wr_en && addr == 6'h14) m_en[63:32] = wdata;
      hist.push_back(src);
      void'(hist.pop_front());
    end
  end

  function automatic bit [31:0] model_read(bit [5:0] a);
    bit [63:0] p;
    bit [31:0] v;
    p = (m_ev | hist[1]) & m_en;
    v = '0;
    case (a)
      6'h00: for (int i = 0; i < 64; i++) if (p[i]) v = 32'h8000_0000 | i;
      6'h10: v = m_ev[63:32];
      6'h14: v = m_en[63:32];
      6'h1C: v = hist[1][63:32];
      6'h20: v = m_ev[31:0];
      6'h24: v = m_en[31:0];
      6'h2C: v = hist[1][31:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  // irq compared every clock (R9)
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq_o actual %0b expected %0b at cycle %0d", irq, m_irq, cycles);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [5:0] a, bit [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(bit [5:0] a, string tag);
    bit [31:0] exp;
    addr = a;
    #0.5;
    exp = model_read(a);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic rd_all(string tag);
    foreach (hist[i]) ; // keep queue referenced
    rd(6'h00, tag); rd(6'h10, tag); rd(6'h14, tag); rd(6'h1C, tag);
    rd(6'h20, tag); rd(6'h24, tag); rd(6'h2C, tag);
  endtask

  initial begin
    rst_n = 0; src = '0; wr_en = 0; addr = '0; wdata = '0;
    tick(3);
    rd_all("R2 reset");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R2 irq actual %0b expected 0", irq); end
    rst_n = 1;
    tick(2);

    // R6 enable readback, R1 placement of the two banks
    wr(6'h24, 32'h0000_0091);
    wr(6'h14, 32'h8000_0001);
    rd(6'h24, "R6 en lo"); rd(6'h14, "R6 en hi"); rd(6'h18, "R1 ack reads 0");
    rd(6'h04, "R1 unmapped"); rd(6'h30, "R1 unmapped");

    // R3/R7 edge on source 4: level after 2 edges, event after 3
    src[4] = 1;
    tick(1); rd(6'h2C, "R7 level early"); rd(6'h20, "R3 event early");
    tick(1); rd(6'h2C, "R7 level seen"); rd(6'h20, "R3 event early");
    tick(1); rd(6'h20, "R3 event set"); rd(6'h00, "R8 vector src4");
    src[4] = 0; tick(3);
    rd(6'h00, "R8 vector held by event");

    // R8 upper bank wins: source 63
    src[63] = 1; tick(4);
    rd(6'h00, "R8 vector src63"); rd(6'h10, "R3 event hi");
    src[63] = 0; tick(3);
    wr(6'h18, 32'h8000_0000); rd(6'h10, "R5 ack clears");
    wr(6'h28, 32'h0000_0000); rd(6'h20, "R5 ack zero no effect");
    rd(6'h00, "R8 vector back to src4");

    // R3 disabled source 5 ignored
    src[5] = 1; tick(4); rd(6'h20, "R3 disabled edge"); src[5] = 0; tick(3);

    // R4 enable while already high
    src[9] = 1; tick(4);
    wr(6'h24, 32'h0000_0291); tick(3);
    rd(6'h20, "R4 no event on enable"); rd(6'h00, "R8 level pending src9");
    src[9] = 0; tick(3); rd(6'h00, "R4 level gone");

    // R5 same-cycle race: acknowledge at each offset from the rise of source 0
    for (int d = 0; d < 5; d++) begin
      wr(6'h28, 32'h0000_0001);
      src[0] = 1;
      tick(d);
      wr(6'h28, 32'h0000_0001);
      tick(3);
      rd(6'h20, "R5 ack vs edge");
      src[0] = 0; tick(3);
    end

    // R3 enable write racing an edge in flight
    wr(6'h24, 32'h0000_0000);
    src[7] = 1; tick(1);
    wr(6'h24, 32'h0000_0080); tick(3);
    rd(6'h20, "R3 enable race");
    src[7] = 0; tick(3);

    // R10 mask keeps event, drops pending
    wr(6'h24, 32'h0000_0000); wr(6'h14, 32'h0);
    tick(2);
    rd_all("R10 masked");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq actual %0b expected 0", irq); end
    wr(6'h24, 32'h0000_0010); tick(2);
    rd(6'h00, "R10 unmask restores");

    // multi-source pattern across banks
    src = 64'h0123_4567_89AB_CDEF;
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h24, 32'hFFFF_FFFF);
    tick(4); rd_all("R8 pattern");
    src = '0; tick(3); rd_all("R7 pattern low");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule